// File: doc/BRIEF.md
# Gain-Control Serial Word Transmitter

This block keeps one 8-bit gain setting for each transmit profile. It follows whichever profile is currently selected. Whenever the gain value of the active profile changes, or a different profile becomes active, the block sends an 8-bit control word by itself. The word goes out over a three-wire serial link (clock, data, active-low enable) to an external variable-gain amplifier. When the frame starts, the block also updates a 4-bit fine DAC gain code. That code steps in 0.5 dB units, from 0.0 dB (0000) to 7.5 dB (1111).

A mode input selects how the gain setting is read. In direct mode the whole setting is the amplifier word. In decoded mode the upper nibble picks a single set bit in the amplifier word, and the lower nibble becomes the DAC fine code. In direct mode the DAC fine code comes from a separate 4-bit input instead. A change that arrives while a frame is in flight is held, and it produces exactly one follow-up frame that carries the newest value.

Top module: `gainSerialTx`

## Requirements
- R1: In direct mode (`altMode`=0 at frame start) the transmitted word equals the active profile's gain setting unchanged.
- R2: In decoded mode (`altMode`=1 at frame start) the upper nibble n of the gain setting gives the transmitted word: n=0 gives 0x00, n=1..8 gives 1<<(n-1), and n=9..15 gives 0x80.
- R3: In decoded mode `dacFine` takes gain bits [3:0] at frame start, and it holds that value while the frame is in flight.
- R4: In direct mode `dacFine` takes `dacFineIn` at frame start. A change of `dacFineIn` alone does not start a frame or alter `dacFine`.
- R5: A frame starts automatically when the active profile's gain value changes or `profileSel` changes. Writing the same value again, or writing an inactive profile, starts no frame.
- R6: Any number of changes during a frame produce exactly one further frame after it ends, and that frame carries the newest value.
- R7: A frame drives `caEnN` low and shifts 8 bits MSB first on `caData`. The data changes only while `caClk` is low and is stable across each rising edge. `caEnN` returns high after the eighth bit. Between frames `caEnN` is high and `caClk` is low.
- R8: Each bit occupies CLK_DIV system cycles: `caClk` is low for CLK_DIV/2 cycles, then high for the rest.
- R9: `busy` is high exactly while `caEnN` is low.
- R10: After reset every gain setting is 0x00, `dacFine` is 0, the link is idle and `busy` is low.
- R11: The word uses the `altMode` value present at frame start. Changing `altMode` alone, even mid-frame, neither alters the current frame nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| gainWe | input | 1 | Write strobe for a gain setting |
| gainWeIdx | input | PROF_W | Profile whose setting is written |
| gainWeData | input | 8 | New gain setting |
| profileSel | input | PROF_W | Active profile |
| altMode | input | 1 | 0 direct, 1 decoded interpretation |
| dacFineIn | input | 4 | DAC fine code used in direct mode |
| caClk | output | 1 | Serial clock to amplifier |
| caData | output | 1 | Serial data to amplifier |
| caEnN | output | 1 | Active-low frame enable |
| busy | output | 1 | Frame in progress |
| dacFine | output | 4 | Fine DAC gain code, 0.5 dB steps |

## Verification
The bench builds the block with CLK_DIV=6 and two profiles. The short divider keeps each frame to 48 cycles, so the bench can hold several changes inside one frame and can measure the exact low and high widths of the serial clock. With two profiles, the bench can write an inactive profile and then switch to it, which includes checking that the reset value of the second profile is sent.

// File: rtl/gainSerialPkg.sv
package gainSerialPkg;
  localparam int WORD_W = 8;
  localparam int NIB_W  = 4;

  typedef struct packed {
    logic load;     // begin frame: capture word and fine code
    logic clkRise;  // raise serial clock
    logic shift;    // drop clock, present next bit
    logic finish;   // drop clock, release enable
  } ctrlStrobe_t;

  function automatic logic [WORD_W-1:0] decodeUpper(input logic [NIB_W-1:0] n);
    logic [WORD_W-1:0] w;
    if (n == '0) w = '0;
    else if (int'(n) > WORD_W) w = WORD_W'(1) << (WORD_W - 1);
    else w = WORD_W'(1) << (int'(n) - 1);
    return w;
  endfunction
endpackage

// File: rtl/gainSerialCtrl.sv
module gainSerialCtrl
  import gainSerialPkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        changeReq,
  output ctrlStrobe_t strobe,
  output logic        busy
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(WORD_W);

  typedef enum logic {ST_IDLE, ST_SHIFT} state_t;
  state_t stateQ;
  logic [CNT_W-1:0] phaseCnt;
  logic [BIT_W-1:0] bitIdx;
  logic pendingQ;
  logic lastPhase;

  always_comb begin
    lastPhase      = (stateQ == ST_SHIFT) && (phaseCnt == CNT_W'(CLK_DIV - 1));
    strobe.load    = (stateQ == ST_IDLE) && pendingQ;
    strobe.clkRise = (stateQ == ST_SHIFT) && (phaseCnt == CNT_W'(HALF - 1));
    strobe.shift   = lastPhase && (bitIdx != BIT_W'(WORD_W - 1));
    strobe.finish  = lastPhase && (bitIdx == BIT_W'(WORD_W - 1));
  end

  assign busy = (stateQ == ST_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      phaseCnt <= '0;
      bitIdx   <= '0;
      pendingQ <= 1'b0;
    end else begin
      pendingQ <= (pendingQ && !strobe.load) || changeReq;
      if (strobe.load) begin
        stateQ   <= ST_SHIFT;
        phaseCnt <= '0;
        bitIdx   <= '0;
      end else if (stateQ == ST_SHIFT) begin
        if (lastPhase) begin
          phaseCnt <= '0;
          bitIdx   <= bitIdx + 1'b1;
          if (strobe.finish) stateQ <= ST_IDLE;
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
      end
    end
  end

  // R6: a held request always becomes a frame on the next edge
  assert_pending_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && pendingQ) |=> busy);
  // R8: phase counter never leaves its bit window
  assert_phase_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(phaseCnt) < CLK_DIV));
  // R7: at most one datapath action per cycle
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.clkRise, strobe.shift, strobe.finish}));
endmodule

// File: rtl/gainSerialPath.sv
module gainSerialPath
  import gainSerialPkg::*;
#(
  parameter int PROFILES = 2,
  parameter int PROF_W   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gainWe,
  input  logic [PROF_W-1:0] gainWeIdx,
  input  logic [WORD_W-1:0] gainWeData,
  input  logic [PROF_W-1:0] profileSel,
  input  logic              altMode,
  input  logic [NIB_W-1:0]  dacFineIn,
  input  ctrlStrobe_t       strobe,
  output logic              changeReq,
  output logic              caClk,
  output logic              caData,
  output logic              caEnN,
  output logic [NIB_W-1:0]  dacFine
);
  logic [WORD_W-1:0] gainRegs [PROFILES];
  logic [WORD_W-1:0] activeGain, prevGain, nextWord, shiftReg;
  logic [PROF_W-1:0] prevProf;
  logic [NIB_W-1:0]  nextFine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PROFILES; i++) gainRegs[i] <= '0;
    end else if (gainWe && (int'(gainWeIdx) < PROFILES)) begin
      gainRegs[gainWeIdx] <= gainWeData;
    end
  end

  always_comb begin
    activeGain = '0;
    if (int'(profileSel) < PROFILES) activeGain = gainRegs[profileSel];
    changeReq = (activeGain != prevGain) || (profileSel != prevProf);
    nextWord  = altMode ? decodeUpper(activeGain[WORD_W-1 -: NIB_W]) : activeGain;
    nextFine  = altMode ? activeGain[NIB_W-1:0] : dacFineIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevGain <= '0;
      prevProf <= '0;
      shiftReg <= '0;
      caClk    <= 1'b0;
      caData   <= 1'b0;
      caEnN    <= 1'b1;
      dacFine  <= '0;
    end else begin
      prevGain <= activeGain;
      prevProf <= profileSel;
      if (strobe.load) begin
        shiftReg <= nextWord;
        caData   <= nextWord[WORD_W-1];
        caEnN    <= 1'b0;
        dacFine  <= nextFine;
      end
      if (strobe.clkRise) caClk <= 1'b1;
      if (strobe.shift) begin
        shiftReg <= shiftReg << 1;
        caData   <= shiftReg[WORD_W-2];
        caClk    <= 1'b0;
      end
      if (strobe.finish) begin
        caClk  <= 1'b0;
        caData <= 1'b0;
        caEnN  <= 1'b1;
      end
    end
  end

  // R7: link idles with clock low whenever enable is released
  assert_idle_clock_R7: assert property (@(posedge clk) disable iff (!rstN)
    caEnN |-> !caClk);
  // R7: data holds while the serial clock stays high
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (caClk && $past(caClk)) |-> $stable(caData));
endmodule

// File: rtl/gainSerialTx.sv
module gainSerialTx
  import gainSerialPkg::*;
#(
  parameter int CLK_DIV  = 8,
  parameter int PROFILES = 2,
  localparam int PROF_W  = (PROFILES > 1) ? $clog2(PROFILES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gainWe,
  input  logic [PROF_W-1:0] gainWeIdx,
  input  logic [7:0]        gainWeData,
  input  logic [PROF_W-1:0] profileSel,
  input  logic              altMode,
  input  logic [3:0]        dacFineIn,
  output logic              caClk,
  output logic              caData,
  output logic              caEnN,
  output logic              busy,
  output logic [3:0]        dacFine
);
  ctrlStrobe_t strobe;
  logic changeReq;

  gainSerialCtrl #(.CLK_DIV(CLK_DIV)) ctrl (
    .clk(clk), .rstN(rstN), .changeReq(changeReq), .strobe(strobe), .busy(busy)
  );

  gainSerialPath #(.PROFILES(PROFILES), .PROF_W(PROF_W)) path (
    .clk(clk), .rstN(rstN), .gainWe(gainWe), .gainWeIdx(gainWeIdx),
    .gainWeData(gainWeData), .profileSel(profileSel), .altMode(altMode),
    .dacFineIn(dacFineIn), .strobe(strobe), .changeReq(changeReq),
    .caClk(caClk), .caData(caData), .caEnN(caEnN), .dacFine(dacFine)
  );

  initial begin
    if (CLK_DIV < 4) $error("CLK_DIV must be at least 4");
  end

  // R9: busy flag and enable line agree
  assert_busy_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy == !caEnN);
  // R3: fine code frozen across a frame
  assert_fine_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(dacFine));
endmodule

// File: tb/gainSerialTx_test.sv
module gainSerialTx_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gainWe = 1'b0;
  logic [0:0] gainWeIdx = '0;
  logic [7:0] gainWeData = '0;
  logic [0:0] profileSel = '0;
  logic altMode = 1'b0;
  logic [3:0] dacFineIn = 4'h9;
  logic caClk, caData, caEnN, busy;
  logic [3:0] dacFine;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  gainSerialTx #(.CLK_DIV(6), .PROFILES(2)) uut (
    .clk(clk), .rstN(rstN), .gainWe(gainWe), .gainWeIdx(gainWeIdx),
    .gainWeData(gainWeData), .profileSel(profileSel), .altMode(altMode),
    .dacFineIn(dacFineIn), .caClk(caClk), .caData(caData), .caEnN(caEnN),
    .busy(busy), .dacFine(dacFine)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeGain(input logic idx, input logic [7:0] val);
    @(negedge clk);
    gainWe = 1'b1; gainWeIdx = idx; gainWeData = val;
    @(negedge clk);
    gainWe = 1'b0;
  endtask

  // capture one frame; flipMode toggles altMode as soon as the frame is seen
  task automatic captureFrame(output bit found, output logic [7:0] word,
                              output int nBits, output int lowW, output int highW,
                              input bit flipMode);
    logic prevClk;
    int guard;
    found = 0; word = '0; nBits = 0; lowW = 0; highW = 0; guard = 0;
    while (caEnN && guard < 200) begin @(negedge clk); guard++; end
    if (caEnN) return;
    found = 1;
    if (flipMode) altMode = ~altMode;
    prevClk = 1'b0;
    guard = 0;
    while (!caEnN && guard < 500) begin
      if (caClk && !prevClk) begin word = {word[6:0], caData}; nBits++; end
      if (nBits == 0 && !caClk) lowW++;
      if (nBits == 1 && caClk) highW++;
      if (!busy) check(0, "R9 busy low during frame", busy, 1);
      prevClk = caClk;
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic expectFrame(input string req, input logic [7:0] expWord, input logic [3:0] expFine);
    bit found; logic [7:0] w; int n, lw, hw;
    captureFrame(found, w, n, lw, hw, 0);
    check(found, {req, " frame present"}, found, 1);
    check(n == 8, {req, " bit count"}, n, 8);
    check(w == expWord, {req, " word"}, w, expWord);
    check(dacFine == expFine, {req, " dacFine"}, dacFine, expFine);
  endtask

  task automatic expectQuiet(input string req);
    int seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!caEnN || busy) seen++;
    end
    check(seen == 0, {req, " no frame"}, seen, 0);
  endtask

  task automatic testReset;
    check(caEnN == 1 && caClk == 0, "R10 idle link", {caEnN, caClk}, 2);
    check(busy == 0, "R10 busy low", busy, 0);
    check(dacFine == 0, "R10 dacFine zero", dacFine, 0);
    expectQuiet("R10 no frame after reset");
    profileSel = 1'b1;
    expectFrame("R10 R5 profile1 reset value", 8'h00, 4'h9);
    profileSel = 1'b0;
    expectFrame("R10 R5 profile0 reset value", 8'h00, 4'h9);
  endtask

  task automatic testDirect;
    bit found; logic [7:0] w; int n, lw, hw;
    writeGain(0, 8'hA5);
    captureFrame(found, w, n, lw, hw, 0);
    check(w == 8'hA5 && n == 8, "R1 R7 direct word", w, 8'hA5);
    check(dacFine == 4'h9, "R4 direct fine from input", dacFine, 9);
    check(lw == 3, "R8 clock low width", lw, 3);
    check(hw == 3, "R8 clock high width", hw, 3);
    check(caEnN && !caClk, "R7 idle after frame", {caEnN, caClk}, 2);
  endtask

  task automatic testNoTrigger;
    writeGain(1, 8'h5C);
    expectQuiet("R5 inactive profile write");
    writeGain(0, 8'hA5);
    expectQuiet("R5 same value write");
    dacFineIn = 4'h2;
    expectQuiet("R4 dacFineIn change");
    check(dacFine == 4'h9, "R4 dacFine unchanged", dacFine, 9);
    altMode = 1'b1;
    expectQuiet("R11 mode change alone");
  endtask

  task automatic testDecoded;
    writeGain(0, 8'h73); expectFrame("R2 R3 n=7", 8'h40, 4'h3);
    writeGain(0, 8'h8F); expectFrame("R2 R3 n=8", 8'h80, 4'hF);
    writeGain(0, 8'h0C); expectFrame("R2 R3 n=0", 8'h00, 4'hC);
    writeGain(0, 8'h1A); expectFrame("R2 R3 n=1", 8'h01, 4'hA);
    writeGain(0, 8'h9B); expectFrame("R2 n=9 clamps", 8'h80, 4'hB);
  endtask

  task automatic testProfile;
    profileSel = 1'b1; expectFrame("R5 switch to profile1", 8'h10, 4'hC);
    profileSel = 1'b0; expectFrame("R5 switch to profile0", 8'h80, 4'hB);
  endtask

  task automatic testCoalesce;
    int guard = 0;
    writeGain(0, 8'h20);
    while (caEnN && guard < 100) begin @(negedge clk); guard++; end
    writeGain(0, 8'h30);
    writeGain(0, 8'h40);
    guard = 0;
    while (!caEnN && guard < 200) begin @(negedge clk); guard++; end
    expectFrame("R6 newest value after frame", 8'h08, 4'h0);
    expectQuiet("R6 only one follow-up");
  endtask

  task automatic testSnapshot;
    bit found; logic [7:0] w; int n, lw, hw;
    writeGain(0, 8'h35);
    captureFrame(found, w, n, lw, hw, 1);
    check(w == 8'h04, "R11 word uses mode at start", w, 8'h04);
    check(dacFine == 4'h5, "R11 R3 fine uses mode at start", dacFine, 5);
    expectQuiet("R11 mid-frame mode change no new frame");
    writeGain(0, 8'h36);
    expectFrame("R1 R4 direct after mode change", 8'h36, 4'h2);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        check(0, "watchdog expired", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirect();
    testNoTrigger();
    testDecoded();
    testProfile();
    testCoalesce();
    testSnapshot();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule